// File: doc/BRIEF.md
# Trap Entry and Delegation Unit

This unit turns a trap strobe into the set of architectural state writes that a hart performs when it takes a trap. The strobe carries a cause word, the faulting PC and an optional bad address. The unit chooses one of four outcomes: a redirect while debug mode is already active, entry into debug mode on an enabled breakpoint, a supervisor-mode handler, or a machine-mode handler. It then presents the new PC, the new privilege, the handler's cause, return-PC and bad-address values, and the status-stack values, each with a single-cycle write enable.

The surrounding core supplies the delegation masks, the two trap-vector registers, the per-privilege breakpoint enables, a flag that says whether a debug cause is already recorded, and the current interrupt-enable bits. All outputs are registered. They appear, together with a done pulse, in the cycle after the strobe. One strobe per cycle is accepted, with no stall.

Top module: `trap_entry_unit`

## Requirements
- R1: While reset is high, and in the first cycle after it, done and every write enable (pc_we, prv_we, dbg_enter, s_csr_we, m_csr_we, s_bad_we, m_bad_we, s_stat_we, m_stat_we, resv_clear) are low.
- R2: When dbg_cause_active is set, a trap whose cause equals 3 (breakpoint) sets pc_next to DBG_ENTRY_PC and any other cause sets it to DBG_TVEC_PC. Only pc_we is raised: privilege, handler registers, status and reservation are not written.
- R3: With no debug cause active, a breakpoint (cause 3) enters debug mode when ebreak_en[cur_prv] is set. Privilege is encoded U=0, S=1, H=2, M=3, and bit n of ebreak_en enables privilege n. Debug entry raises dbg_enter with dbg_cause_code 1, dbg_prv_save equal to the old privilege and dbg_pc_save equal to trap_epc. It also sets prv_next to 3 and pc_next to DBG_ENTRY_PC.
- R4: Bit XLEN-1 of the cause marks an interrupt, and the cause index is the cause with that bit cleared. Interrupts consult int_deleg and exceptions consult exc_deleg. A trap goes to supervisor mode only when cur_prv is 0 or 1, the index is below XLEN and the mask bit at the index is 1. Otherwise it goes to machine mode.
- R5: Supervisor entry raises s_csr_we with cause_out equal to the cause and epc_out equal to trap_epc. s_bad_we is raised only when badaddr_valid is set, with bad_out equal to trap_badaddr. The other outputs are pc_next equal to stvec, prv_next equal to 1, and s_stat_we with pie_next equal to sie_in and pp_next equal to the old privilege. A raised status enable means the target mode's interrupt enable is cleared.
- R6: Machine entry sets pc_next to mtvec with bit 0 cleared. When mtvec bit 0 is 1 and the trap is an interrupt, 4 times the cause index is added. Machine entry also raises m_csr_we (and m_bad_we only when badaddr_valid is set) and sets prv_next to 3. It raises m_stat_we with pie_next equal to mie_in and pp_next equal to the old privilege.
- R7: resv_clear pulses exactly when a trap is routed to supervisor or machine mode, and never for either debug outcome.
- R8: Outputs and a one-cycle done pulse appear in the cycle after the strobe. A cycle without a strobe produces no enable in the next cycle.
- R9: Strobes on consecutive cycles are each committed in turn, with no lost or merged trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trap_valid | input | 1 | Trap strobe |
| trap_cause | input | XLEN | Cause word, MSB marks interrupt |
| trap_epc | input | XLEN | PC of the trapping instruction |
| trap_badaddr | input | XLEN | Faulting address |
| badaddr_valid | input | 1 | trap_badaddr is meaningful |
| cur_prv | input | 2 | Current privilege (U=0,S=1,H=2,M=3) |
| exc_deleg | input | XLEN | Exception delegation mask |
| int_deleg | input | XLEN | Interrupt delegation mask |
| stvec | input | XLEN | Supervisor trap vector |
| mtvec | input | XLEN | Machine trap vector, bit 0 selects vectoring |
| dbg_cause_active | input | 1 | A debug cause is already recorded |
| ebreak_en | input | 4 | Breakpoint-to-debug enable per privilege |
| sie_in | input | 1 | Current supervisor interrupt enable |
| mie_in | input | 1 | Current machine interrupt enable |
| done | output | 1 | Commit pulse |
| pc_we | output | 1 | PC write enable |
| pc_next | output | XLEN | New PC |
| prv_we | output | 1 | Privilege write enable |
| prv_next | output | 2 | New privilege |
| dbg_enter | output | 1 | Debug-entry register write enable |
| dbg_cause_code | output | 3 | Debug cause value to record |
| dbg_prv_save | output | 2 | Privilege saved on debug entry |
| dbg_pc_save | output | XLEN | PC saved on debug entry |
| s_csr_we | output | 1 | Write supervisor cause and return PC |
| m_csr_we | output | 1 | Write machine cause and return PC |
| s_bad_we | output | 1 | Write supervisor bad address |
| m_bad_we | output | 1 | Write machine bad address |
| cause_out | output | XLEN | Cause value for the handler |
| epc_out | output | XLEN | Return PC for the handler |
| bad_out | output | XLEN | Bad address for the handler |
| s_stat_we | output | 1 | Update supervisor status stack |
| m_stat_we | output | 1 | Update machine status stack |
| pie_next | output | 1 | New previous-interrupt-enable value |
| pp_next | output | 2 | New previous-privilege value |
| resv_clear | output | 1 | Drop the load reservation |

## Verification
A wrong routing decision shows up in the very next cycle as the wrong handler enable and a pc_next pointing at the other vector. A wrong cause index shows up as an off-by-four vectored PC or as a delegation that ignores an out-of-range index. A wrong saved privilege or saved enable shows up in pp_next or pie_next of the same commit. The sweep covers every privilege, both debug states, both mask patterns, both vector modes and causes inside and outside the mask width. Every commit is compared field by field in the cycle after its strobe.

// File: rtl/trap_pkg.sv
package trap_pkg;

    typedef enum logic [1:0] {
        PRV_USER  = 2'd0,
        PRV_SUPER = 2'd1,
        PRV_HYP   = 2'd2,
        PRV_MACH  = 2'd3
    } prv_e;

    typedef enum logic [1:0] {
        RT_DBG_REDIRECT = 2'd0,
        RT_DBG_ENTER    = 2'd1,
        RT_SUPER        = 2'd2,
        RT_MACH         = 2'd3
    } route_e;

    localparam logic [2:0] DBG_CAUSE_SWBP = 3'd1;
    localparam int unsigned BKPT_CODE     = 3;

    // privilege may take a delegated trap only at or below supervisor level
    function automatic logic prv_may_delegate(input logic [1:0] prv);
        return prv <= PRV_SUPER;
    endfunction

endpackage

// File: rtl/trap_classify.sv
module trap_classify #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0]     cause,
    input  logic [1:0]          cur_prv,
    input  logic                dbg_active,
    input  logic [3:0]          ebreak_en,
    input  logic [XLEN-1:0]     exc_deleg,
    input  logic [XLEN-1:0]     int_deleg,
    output trap_pkg::route_e    route,
    output logic                is_int,
    output logic                is_bkpt,
    output logic [XLEN-1:0]     cidx
);
    import trap_pkg::*;

    localparam int IDX_W = $clog2(XLEN);
    localparam logic [XLEN-1:0] XLEN_V = XLEN'(XLEN);

    logic [XLEN-1:0] mask_sel;
    logic            in_range;
    logic            deleg_hit;

    assign is_int   = cause[XLEN-1];
    assign cidx     = {1'b0, cause[XLEN-2:0]};
    assign is_bkpt  = (cause == XLEN'(BKPT_CODE));
    assign mask_sel = is_int ? int_deleg : exc_deleg;
    assign in_range = (cidx < XLEN_V);
    assign deleg_hit = in_range && mask_sel[cidx[IDX_W-1:0]];

    always_comb begin
        if (dbg_active)
            route = RT_DBG_REDIRECT;
        else if (is_bkpt && ebreak_en[cur_prv])
            route = RT_DBG_ENTER;
        else if (prv_may_delegate(cur_prv) && deleg_hit)
            route = RT_SUPER;
        else
            route = RT_MACH;
    end

endmodule

// File: rtl/trap_target_pc.sv
module trap_target_pc #(
    parameter int              XLEN         = 32,
    parameter logic [XLEN-1:0] DBG_ENTRY_PC = XLEN'('h800),
    parameter logic [XLEN-1:0] DBG_TVEC_PC  = XLEN'('h808)
) (
    input  trap_pkg::route_e route,
    input  logic             is_int,
    input  logic             is_bkpt,
    input  logic [XLEN-1:0]  cidx,
    input  logic [XLEN-1:0]  stvec,
    input  logic [XLEN-1:0]  mtvec,
    output logic [XLEN-1:0]  pc
);
    import trap_pkg::*;

    logic [XLEN-1:0] m_base;
    logic [XLEN-1:0] m_offset;

    assign m_base   = {mtvec[XLEN-1:1], 1'b0};
    assign m_offset = (mtvec[0] && is_int) ? (cidx << 2) : '0;

    always_comb begin
        unique case (route)
            RT_DBG_REDIRECT: pc = is_bkpt ? DBG_ENTRY_PC : DBG_TVEC_PC;
            RT_DBG_ENTER:    pc = DBG_ENTRY_PC;
            RT_SUPER:        pc = stvec;
            default:         pc = m_base + m_offset;
        endcase
    end

endmodule

// File: rtl/trap_status_stack.sv
module trap_status_stack (
    input  trap_pkg::route_e route,
    input  logic [1:0]       cur_prv,
    input  logic             sie_in,
    input  logic             mie_in,
    output logic             pie_val,
    output logic [1:0]       pp_val
);
    import trap_pkg::*;

    always_comb begin
        if (route == RT_SUPER) begin
            pie_val = sie_in;
            pp_val  = {1'b0, cur_prv[0]};
        end else begin
            pie_val = mie_in;
            pp_val  = cur_prv;
        end
    end

endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit #(
    parameter int              XLEN         = 32,
    parameter logic [XLEN-1:0] DBG_ENTRY_PC = XLEN'('h800),
    parameter logic [XLEN-1:0] DBG_TVEC_PC  = XLEN'('h808)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            trap_valid,
    input  logic [XLEN-1:0] trap_cause,
    input  logic [XLEN-1:0] trap_epc,
    input  logic [XLEN-1:0] trap_badaddr,
    input  logic            badaddr_valid,
    input  logic [1:0]      cur_prv,
    input  logic [XLEN-1:0] exc_deleg,
    input  logic [XLEN-1:0] int_deleg,
    input  logic [XLEN-1:0] stvec,
    input  logic [XLEN-1:0] mtvec,
    input  logic            dbg_cause_active,
    input  logic [3:0]      ebreak_en,
    input  logic            sie_in,
    input  logic            mie_in,
    output logic            done,
    output logic            pc_we,
    output logic [XLEN-1:0] pc_next,
    output logic            prv_we,
    output logic [1:0]      prv_next,
    output logic            dbg_enter,
    output logic [2:0]      dbg_cause_code,
    output logic [1:0]      dbg_prv_save,
    output logic [XLEN-1:0] dbg_pc_save,
    output logic            s_csr_we,
    output logic            m_csr_we,
    output logic            s_bad_we,
    output logic            m_bad_we,
    output logic [XLEN-1:0] cause_out,
    output logic [XLEN-1:0] epc_out,
    output logic [XLEN-1:0] bad_out,
    output logic            s_stat_we,
    output logic            m_stat_we,
    output logic            pie_next,
    output logic [1:0]      pp_next,
    output logic            resv_clear
);
    import trap_pkg::*;

    route_e          route;
    logic            is_int;
    logic            is_bkpt;
    logic [XLEN-1:0] cidx;
    logic [XLEN-1:0] tgt_pc;
    logic            pie_val;
    logic [1:0]      pp_val;

    trap_classify #(.XLEN(XLEN)) u_classify (
        .cause      (trap_cause),
        .cur_prv    (cur_prv),
        .dbg_active (dbg_cause_active),
        .ebreak_en  (ebreak_en),
        .exc_deleg  (exc_deleg),
        .int_deleg  (int_deleg),
        .route      (route),
        .is_int     (is_int),
        .is_bkpt    (is_bkpt),
        .cidx       (cidx)
    );

    trap_target_pc #(
        .XLEN         (XLEN),
        .DBG_ENTRY_PC (DBG_ENTRY_PC),
        .DBG_TVEC_PC  (DBG_TVEC_PC)
    ) u_target (
        .route   (route),
        .is_int  (is_int),
        .is_bkpt (is_bkpt),
        .cidx    (cidx),
        .stvec   (stvec),
        .mtvec   (mtvec),
        .pc      (tgt_pc)
    );

    trap_status_stack u_stack (
        .route   (route),
        .cur_prv (cur_prv),
        .sie_in  (sie_in),
        .mie_in  (mie_in),
        .pie_val (pie_val),
        .pp_val  (pp_val)
    );

    // enables are single-cycle pulses; data fields hold until the next commit
    always_ff @(posedge clk) begin
        if (rst) begin
            done           <= 1'b0;
            pc_we          <= 1'b0;
            pc_next        <= '0;
            prv_we         <= 1'b0;
            prv_next       <= PRV_MACH;
            dbg_enter      <= 1'b0;
            dbg_cause_code <= '0;
            dbg_prv_save   <= '0;
            dbg_pc_save    <= '0;
            s_csr_we       <= 1'b0;
            m_csr_we       <= 1'b0;
            s_bad_we       <= 1'b0;
            m_bad_we       <= 1'b0;
            cause_out      <= '0;
            epc_out        <= '0;
            bad_out        <= '0;
            s_stat_we      <= 1'b0;
            m_stat_we      <= 1'b0;
            pie_next       <= 1'b0;
            pp_next        <= '0;
            resv_clear     <= 1'b0;
        end else begin
            done       <= trap_valid;
            pc_we      <= trap_valid;
            prv_we     <= 1'b0;
            dbg_enter  <= 1'b0;
            s_csr_we   <= 1'b0;
            m_csr_we   <= 1'b0;
            s_bad_we   <= 1'b0;
            m_bad_we   <= 1'b0;
            s_stat_we  <= 1'b0;
            m_stat_we  <= 1'b0;
            resv_clear <= 1'b0;
            if (trap_valid) begin
                pc_next <= tgt_pc;
                unique case (route)
                    RT_DBG_REDIRECT: begin
                    end
                    RT_DBG_ENTER: begin
                        dbg_enter      <= 1'b1;
                        dbg_cause_code <= DBG_CAUSE_SWBP;
                        dbg_prv_save   <= cur_prv;
                        dbg_pc_save    <= trap_epc;
                        prv_we         <= 1'b1;
                        prv_next       <= PRV_MACH;
                    end
                    RT_SUPER: begin
                        s_csr_we   <= 1'b1;
                        s_bad_we   <= badaddr_valid;
                        s_stat_we  <= 1'b1;
                        prv_we     <= 1'b1;
                        prv_next   <= PRV_SUPER;
                        resv_clear <= 1'b1;
                    end
                    default: begin
                        m_csr_we   <= 1'b1;
                        m_bad_we   <= badaddr_valid;
                        m_stat_we  <= 1'b1;
                        prv_we     <= 1'b1;
                        prv_next   <= PRV_MACH;
                        resv_clear <= 1'b1;
                    end
                endcase
                if (route == RT_SUPER || route == RT_MACH) begin
                    cause_out <= trap_cause;
                    epc_out   <= trap_epc;
                    bad_out   <= trap_badaddr;
                    pie_next  <= pie_val;
                    pp_next   <= pp_val;
                end
            end
        end
    end

endmodule

// File: rtl/trap_entry_chk.sv
module trap_entry_chk (
    input logic       clk,
    input logic       rst,
    input logic       trap_valid,
    input logic       badaddr_valid,
    input logic [1:0] cur_prv,
    input logic       done,
    input logic       pc_we,
    input logic       prv_we,
    input logic [1:0] prv_next,
    input logic       dbg_enter,
    input logic       s_csr_we,
    input logic       m_csr_we,
    input logic       s_bad_we,
    input logic       m_bad_we,
    input logic       resv_clear
);

    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!done && !pc_we && !prv_we && !resv_clear));

    p_done_after_strobe_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(trap_valid));

    p_strobe_commits_r9: assert property (@(posedge clk) disable iff (rst)
        trap_valid |=> (done && pc_we));

    p_single_target_r4: assert property (@(posedge clk) disable iff (rst)
        $onehot0({dbg_enter, s_csr_we, m_csr_we}));

    p_super_prv_r5: assert property (@(posedge clk) disable iff (rst)
        s_csr_we |-> (prv_we && prv_next == 2'd1 && $past(cur_prv) <= 2'd1));

    p_super_bad_r5: assert property (@(posedge clk) disable iff (rst)
        s_bad_we |-> (s_csr_we && $past(badaddr_valid)));

    p_mach_bad_r6: assert property (@(posedge clk) disable iff (rst)
        m_bad_we |-> (m_csr_we && $past(badaddr_valid)));

    p_dbg_prv_r3: assert property (@(posedge clk) disable iff (rst)
        dbg_enter |-> (prv_we && prv_next == 2'd3));

    p_resv_routed_r7: assert property (@(posedge clk) disable iff (rst)
        resv_clear |-> (s_csr_we || m_csr_we));

    p_routed_resv_r7: assert property (@(posedge clk) disable iff (rst)
        (s_csr_we || m_csr_we) |-> resv_clear);

    p_redirect_only_pc_r2: assert property (@(posedge clk) disable iff (rst)
        (pc_we && !prv_we) |-> (!resv_clear && !dbg_enter && !s_csr_we && !m_csr_we));

endmodule

bind trap_entry_unit trap_entry_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .trap_valid    (trap_valid),
    .badaddr_valid (badaddr_valid),
    .cur_prv       (cur_prv),
    .done          (done),
    .pc_we         (pc_we),
    .prv_we        (prv_we),
    .prv_next      (prv_next),
    .dbg_enter     (dbg_enter),
    .s_csr_we      (s_csr_we),
    .m_csr_we      (m_csr_we),
    .s_bad_we      (s_bad_we),
    .m_bad_we      (m_bad_we),
    .resv_clear    (resv_clear)
);

// File: tb/sim_trap_entry_unit.sv
`timescale 1ns/1ps
module sim_trap_entry_unit;

    localparam int XLEN = 32;
    localparam logic [31:0] ENTRY = 32'h800;
    localparam logic [31:0] TVEC  = 32'h808;
    localparam logic [31:0] STV   = 32'h0000_4000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        trap_valid = 1'b0;
    logic [31:0] trap_cause = '0, trap_epc = '0, trap_badaddr = '0;
    logic        badaddr_valid = 1'b0;
    logic [1:0]  cur_prv = '0;
    logic [31:0] exc_deleg = '0, int_deleg = '0, stvec = '0, mtvec = '0;
    logic        dbg_cause_active = 1'b0;
    logic [3:0]  ebreak_en = '0;
    logic        sie_in = 1'b0, mie_in = 1'b0;

    logic        done, pc_we, prv_we, dbg_enter, s_csr_we, m_csr_we;
    logic        s_bad_we, m_bad_we, s_stat_we, m_stat_we, pie_next, resv_clear;
    logic [31:0] pc_next, dbg_pc_save, cause_out, epc_out, bad_out;
    logic [1:0]  prv_next, dbg_prv_save, pp_next;
    logic [2:0]  dbg_cause_code;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    trap_entry_unit #(.XLEN(XLEN), .DBG_ENTRY_PC(ENTRY), .DBG_TVEC_PC(TVEC)) u0 (
        .clk(clk), .rst(rst), .trap_valid(trap_valid), .trap_cause(trap_cause),
        .trap_epc(trap_epc), .trap_badaddr(trap_badaddr), .badaddr_valid(badaddr_valid),
        .cur_prv(cur_prv), .exc_deleg(exc_deleg), .int_deleg(int_deleg),
        .stvec(stvec), .mtvec(mtvec), .dbg_cause_active(dbg_cause_active),
        .ebreak_en(ebreak_en), .sie_in(sie_in), .mie_in(mie_in),
        .done(done), .pc_we(pc_we), .pc_next(pc_next), .prv_we(prv_we),
        .prv_next(prv_next), .dbg_enter(dbg_enter), .dbg_cause_code(dbg_cause_code),
        .dbg_prv_save(dbg_prv_save), .dbg_pc_save(dbg_pc_save),
        .s_csr_we(s_csr_we), .m_csr_we(m_csr_we), .s_bad_we(s_bad_we),
        .m_bad_we(m_bad_we), .cause_out(cause_out), .epc_out(epc_out),
        .bad_out(bad_out), .s_stat_we(s_stat_we), .m_stat_we(m_stat_we),
        .pie_next(pie_next), .pp_next(pp_next), .resv_clear(resv_clear)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic quiet_check(input string req);
        chk(req, "done", done, 0);
        chk(req, "pc_we", pc_we, 0);
        chk(req, "prv_we", prv_we, 0);
        chk(req, "handler we", {dbg_enter, s_csr_we, m_csr_we, s_bad_we, m_bad_we}, 0);
        chk(req, "status we", {s_stat_we, m_stat_we}, 0);
        chk(req, "resv_clear", resv_clear, 0);
    endtask

    task automatic run_one(input logic [1:0] p, input logic dbg, input logic [31:0] c,
                           input logic sel, input logic mv0, input logic [3:0] een,
                           input logic bv, input logic si, input logic mi, input int n);
        logic        isint, bk, dbit;
        logic [31:0] idx, ev, iv, dv, mt, pce, epc, bad;
        int          rt;
        string       tag;
        ev  = sel ? 32'hFFFF_FFFF : 32'h0000_0100;
        iv  = sel ? 32'hFFFF_FFFF : 32'h0000_0020;
        mt  = 32'h0000_8000 | {31'd0, mv0};
        epc = 32'h1000_0000 + 32'(n * 4);
        bad = 32'hBAD0_0000 + c;
        isint = c[31];
        idx   = {1'b0, c[30:0]};
        bk    = (c == 32'd3);
        dv    = isint ? iv : ev;
        dbit  = (idx < 32) ? ((dv >> idx) & 1) != 0 : 1'b0;
        if (dbg) rt = 0;
        else if (bk && een[p]) rt = 1;
        else if (p <= 2'd1 && dbit) rt = 2;
        else rt = 3;
        case (rt)
            0: begin pce = bk ? ENTRY : TVEC; tag = "R2"; end
            1: begin pce = ENTRY; tag = "R3"; end
            2: begin pce = STV; tag = "R5"; end
            default: begin
                pce = (mt & ~32'd1) + ((mv0 && isint) ? idx * 4 : 32'd0);
                tag = "R6";
            end
        endcase

        trap_valid = 1'b1; trap_cause = c; trap_epc = epc; trap_badaddr = bad;
        badaddr_valid = bv; cur_prv = p; exc_deleg = ev; int_deleg = iv;
        stvec = STV; mtvec = mt; dbg_cause_active = dbg; ebreak_en = een;
        sie_in = si; mie_in = mi;
        @(negedge clk);
        trap_valid = 1'b0;

        chk("R9", "done on consecutive strobe", done, 1);
        chk("R8", "pc_we", pc_we, 1);
        chk(tag, "pc_next", pc_next, pce);
        chk("R4", "route S", s_csr_we, rt == 2);
        chk("R4", "route M", m_csr_we, rt == 3);
        chk("R3", "dbg_enter", dbg_enter, rt == 1);
        chk(tag, "prv_we", prv_we, rt != 0);
        chk("R7", "resv_clear", resv_clear, rt >= 2);
        chk("R5", "s_bad_we", s_bad_we, rt == 2 && bv);
        chk("R6", "m_bad_we", m_bad_we, rt == 3 && bv);
        chk(tag, "s_stat_we", s_stat_we, rt == 2);
        chk(tag, "m_stat_we", m_stat_we, rt == 3);
        if (rt == 1) begin
            chk("R3", "prv_next", prv_next, 3);
            chk("R3", "dbg_cause_code", dbg_cause_code, 1);
            chk("R3", "dbg_prv_save", dbg_prv_save, p);
            chk("R3", "dbg_pc_save", dbg_pc_save, epc);
        end
        if (rt >= 2) begin
            chk(tag, "prv_next", prv_next, rt == 2 ? 2'd1 : 2'd3);
            chk(tag, "cause_out", cause_out, c);
            chk(tag, "epc_out", epc_out, epc);
            chk(tag, "bad_out", bad_out, bad);
            chk(tag, "pie_next", pie_next, rt == 2 ? si : mi);
            chk(tag, "pp_next", pp_next, p);
        end
    endtask

    initial begin : watchdog
        #(200000 * 5);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=expired expected=completion");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] causes [7];
        int n;
        causes[0] = 32'd3;
        causes[1] = 32'd8;
        causes[2] = 32'd13;
        causes[3] = 32'h8000_0005;
        causes[4] = 32'h8000_0007;
        causes[5] = 32'd40;
        causes[6] = 32'h8000_0028;
        n = 0;

        repeat (3) @(negedge clk);
        quiet_check("R1");
        rst = 1'b0;
        @(negedge clk);
        quiet_check("R1");

        for (int p = 0; p < 4; p++)
            for (int dbg = 0; dbg < 2; dbg++)
                for (int ci = 0; ci < 7; ci++)
                    for (int sel = 0; sel < 2; sel++)
                        for (int mv = 0; mv < 2; mv++)
                            for (int ee = 0; ee < 2; ee++) begin
                                run_one(2'(p), dbg[0], causes[ci], sel[0], mv[0],
                                        ee[0] ? 4'hF : 4'h0, sel[0] ^ mv[0],
                                        n[0], n[1], n);
                                n++;
                            end

        // single enables: only the current privilege's bit counts (R3)
        for (int p = 0; p < 4; p++) begin
            run_one(2'(p), 1'b0, 32'd3, 1'b0, 1'b0, 4'(1 << ((p + 1) % 4)), 1'b1, 1'b1, 1'b0, n);
            n++;
            run_one(2'(p), 1'b0, 32'd3, 1'b0, 1'b0, 4'(1 << p), 1'b1, 1'b0, 1'b1, n);
            n++;
        end

        // no strobe -> no enables on the following cycle (R8)
        @(negedge clk);
        quiet_check("R8");
        @(negedge clk);
        quiet_check("R8");

        finished = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule